// File: doc/BRIEF.md
# Region-Tagged Translation Buffer with Per-Page Subblocks

This block is a small fully associative address translation cache. Each entry carries one tag for an aligned 64KB virtual region and, beside that tag, sixteen independent slots, one for every 4KB page in the region. Each slot holds its own valid flag, its own full physical page number and its own attribute bits. Because nothing ties one slot's physical page to another's, any mix of base-page mappings that falls in one region can share one entry.

A lookup presents a virtual address. One clock later the block reports a hit flag, the physical address (the slot's page number joined to the untranslated page offset) and the slot's attributes. A fill installs one page mapping. It merges into the entry whose region tag already matches. Otherwise it claims an empty entry, or evicts a whole entry chosen by a rotating pointer. Single pages can be invalidated, and the whole buffer can be flushed. An entry whose sixteen valid flags are all clear is free again.

Top module: `subblock_tlb`

## Requirements
- R1: After synchronous reset every page misses: `lk_hit`, `lk_paddr` and `lk_attr` read zero.
- R2: A lookup hits when some entry's region tag equals vaddr[31:16] and that entry's slot selected by vaddr[15:12] is valid. The result appears on the outputs in the cycle after `lk_valid` is sampled, and `lk_hit` is low in any cycle that follows a cycle without a request.
- R3: On a hit `lk_paddr` is {stored page number, vaddr[11:0]} and `lk_attr` is the slot's stored attributes. On a miss both read zero.
- R4: A fill to a region that is already present writes only its own slot. The other slots keep their page numbers and attributes, and their page numbers need not be related.
- R5: A fill to a page that is already valid overwrites its page number and attributes.
- R6: A fill for a new region uses an entry with no valid slots while one exists, so up to ENTRIES distinct regions stay resident together.
- R7: When no entry is free, a new region evicts the entry selected by a round-robin pointer. The pointer starts at entry 0 after reset and advances by one per eviction. All sixteen slots of the victim are dropped.
- R8: Invalidating a page clears only that page's slot. Other pages of the region still hit, and invalidating an absent page changes nothing.
- R9: An entry whose last valid slot is invalidated becomes free and is reused before the round-robin victim.
- R10: `flush_all` clears every slot of every entry.
- R11: A lookup in the same cycle as a fill of the same page returns the contents from before the fill.
- R12: Operations are prioritised flush, then invalidate, then fill. A lower-priority operation requested in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_hit | output | 1 | Registered hit flag |
| lk_paddr | output | PPN_W+PAGE_BITS | Translated physical address, zero on miss |
| lk_attr | output | ATTR_W | Attributes of the hit page, zero on miss |
| fl_valid | input | 1 | Fill request |
| fl_vpn | input | VA_W-PAGE_BITS | Virtual page number to install |
| fl_ppn | input | PPN_W | Physical page number to install |
| fl_attr | input | ATTR_W | Attributes to install |
| inv_valid | input | 1 | Single-page invalidate request |
| inv_vpn | input | VA_W-PAGE_BITS | Virtual page number to invalidate |
| flush_all | input | 1 | Clear the whole buffer |

## Verification
A corrupted valid flag or tag shows at the ports as a wrong hit or miss on the very next lookup of that page, one cycle after the request. A slot written into the wrong entry or the wrong position shows as a wrong page number or attributes on a neighbouring page of the same region, so lookups cover several slots per region. A rotating pointer or free-entry search that goes wrong stays hidden until the buffer is full. It then appears as the wrong region going missing on the next eviction, which is why eviction order is checked across two successive replacements and after a slot-by-slot release.

// File: rtl/subblock_tlb_pkg.sv
package subblock_tlb_pkg;

  // Operation granted to the update logic in a given cycle
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_FLUSH = 2'd1,
    OP_DROP  = 2'd2,
    OP_FILL  = 2'd3
  } tlb_op_e;

endpackage

// File: rtl/subblock_tlb_tags.sv
module subblock_tlb_tags
  import subblock_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 16,
  parameter int SUBS    = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int SUB_W  = $clog2(SUBS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TAG_W-1:0]   lk_tag,
  input  logic [SUB_W-1:0]   lk_sub,
  input  logic [TAG_W-1:0]   fl_tag,
  input  logic [TAG_W-1:0]   inv_tag,
  input  logic [SUB_W-1:0]   inv_sub,
  input  tlb_op_e            op,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [SUB_W-1:0]   fill_sub,
  input  logic               fill_alloc,
  output logic [ENTRIES-1:0] lk_hit_vec,
  output logic [ENTRIES-1:0] fl_match,
  output logic [ENTRIES-1:0] free_vec
);

  logic [TAG_W-1:0]            tag_q [ENTRIES];
  logic [ENTRIES-1:0][SUBS-1:0] valid_q;
  logic [ENTRIES-1:0]          in_use;
  logic [ENTRIES-1:0]          inv_hit;
  logic [SUBS-1:0]             fill_bit;

  // Per-entry comparators, one set per port
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign in_use[e]     = |valid_q[e];
    assign free_vec[e]   = ~in_use[e];
    assign lk_hit_vec[e] = in_use[e] && (tag_q[e] == lk_tag) && valid_q[e][lk_sub];
    assign fl_match[e]   = in_use[e] && (tag_q[e] == fl_tag);
    assign inv_hit[e]    = in_use[e] && (tag_q[e] == inv_tag) && valid_q[e][inv_sub];
  end

  assign fill_bit = SUBS'(1) << fill_sub;

  // Slot valid flags: reset, flush, single drop, fill or merge
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      case (op)
        OP_FLUSH: valid_q <= '0;
        OP_DROP: begin
          for (int e = 0; e < ENTRIES; e++) begin
            if (inv_hit[e]) valid_q[e][inv_sub] <= 1'b0;
          end
        end
        OP_FILL: begin
          if (fill_alloc) valid_q[fill_idx] <= fill_bit;
          else            valid_q[fill_idx] <= valid_q[fill_idx] | fill_bit;
        end
        default: ;
      endcase
    end
  end

  // Region tags need no reset: an entry with no valid slot never matches
  always_ff @(posedge clk) begin
    if (op == OP_FILL && fill_alloc) tag_q[fill_idx] <= fl_tag;
  end

  AST_REGION_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fl_match)); // R4
  AST_LOOKUP_UNIQUE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_hit_vec)); // R2
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (op == OP_FLUSH) |=> (&free_vec)); // R10
  AST_DROP_ONE: assert property (@(posedge clk) disable iff (rst)
    (op == OP_DROP && |inv_hit) |=> ($countones(valid_q) + 1 == $countones($past(valid_q)))); // R8
  AST_FILL_SETS: assert property (@(posedge clk) disable iff (rst)
    (op == OP_FILL) |=> valid_q[$past(fill_idx)][$past(fill_sub)]); // R4

endmodule

// File: rtl/subblock_tlb_victim.sv
module subblock_tlb_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] free_vec,
  input  logic               take,
  output logic [IDX_W-1:0]   victim_idx
);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] first_free;
  logic             any_free;

  // Lowest-numbered free entry
  always_comb begin
    first_free = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (free_vec[i]) first_free = IDX_W'(i);
    end
  end

  assign any_free   = |free_vec;
  assign victim_idx = any_free ? first_free : rr_q;

  // Rotating eviction pointer, moved only by an actual eviction
  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (take && !any_free) begin
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  AST_FREE_FIRST: assert property (@(posedge clk) disable iff (rst)
    (take && any_free) |-> free_vec[victim_idx]); // R6
  AST_RR_STEP: assert property (@(posedge clk) disable iff (rst)
    (take && !any_free) |=> (rr_q != $past(rr_q))); // R7
  AST_RR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(take && !any_free) |=> $stable(rr_q)); // R9

endmodule

// File: rtl/subblock_tlb_store.sv
module subblock_tlb_store #(
  parameter int DW = 24,
  parameter int AW = 7,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rd
);

  logic [DW-1:0] mem [DEPTH];

  // Simple dual-port RAM, read-before-write on an address collision
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end

endmodule

// File: rtl/subblock_tlb.sv
module subblock_tlb
  import subblock_tlb_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PPN_W     = 20,
  parameter int ATTR_W    = 4,
  parameter int ENTRIES   = 8,
  parameter int PAGE_BITS = 12,
  parameter int SUB_BITS  = 4,
  localparam int SUBS      = 1 << SUB_BITS,
  localparam int REGION_LO = PAGE_BITS + SUB_BITS,
  localparam int TAG_W     = VA_W - REGION_LO,
  localparam int VPN_W     = VA_W - PAGE_BITS,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int DW        = PPN_W + ATTR_W,
  localparam int AW        = IDX_W + SUB_BITS
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      lk_valid,
  input  logic [VA_W-1:0]           lk_vaddr,
  output logic                      lk_hit,
  output logic [PPN_W+PAGE_BITS-1:0] lk_paddr,
  output logic [ATTR_W-1:0]         lk_attr,
  input  logic                      fl_valid,
  input  logic [VPN_W-1:0]          fl_vpn,
  input  logic [PPN_W-1:0]          fl_ppn,
  input  logic [ATTR_W-1:0]         fl_attr,
  input  logic                      inv_valid,
  input  logic [VPN_W-1:0]          inv_vpn,
  input  logic                      flush_all
);

  tlb_op_e            op;
  logic [TAG_W-1:0]   lk_tag, fl_tag, inv_tag;
  logic [SUB_BITS-1:0] lk_sub, fl_sub, inv_sub;
  logic [ENTRIES-1:0] lk_hit_vec, fl_match, free_vec;
  logic [IDX_W-1:0]   lk_idx, fl_idx, victim_idx, fill_idx;
  logic               fill_alloc;
  logic               take;
  logic [DW-1:0]      rd_data;
  logic               hit_q;
  logic [PAGE_BITS-1:0] off_q;

  // Address fields
  assign lk_tag  = lk_vaddr[VA_W-1:REGION_LO];
  assign lk_sub  = lk_vaddr[REGION_LO-1:PAGE_BITS];
  assign fl_tag  = fl_vpn[VPN_W-1:SUB_BITS];
  assign fl_sub  = fl_vpn[SUB_BITS-1:0];
  assign inv_tag = inv_vpn[VPN_W-1:SUB_BITS];
  assign inv_sub = inv_vpn[SUB_BITS-1:0];

  // Fixed priority among update requests
  always_comb begin
    if (flush_all)      op = OP_FLUSH;
    else if (inv_valid) op = OP_DROP;
    else if (fl_valid)  op = OP_FILL;
    else                op = OP_IDLE;
  end

  // One-hot to index (vectors are at most one-hot)
  always_comb begin
    lk_idx = '0;
    fl_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_hit_vec[i]) lk_idx = lk_idx | IDX_W'(i);
      if (fl_match[i])   fl_idx = fl_idx | IDX_W'(i);
    end
  end

  assign fill_alloc = ~|fl_match;
  assign fill_idx   = fill_alloc ? victim_idx : fl_idx;
  assign take       = (op == OP_FILL) && fill_alloc;

  subblock_tlb_tags #(
    .ENTRIES (ENTRIES),
    .TAG_W   (TAG_W),
    .SUBS    (SUBS)
  ) tags_i (
    .clk        (clk),
    .rst        (rst),
    .lk_tag     (lk_tag),
    .lk_sub     (lk_sub),
    .fl_tag     (fl_tag),
    .inv_tag    (inv_tag),
    .inv_sub    (inv_sub),
    .op         (op),
    .fill_idx   (fill_idx),
    .fill_sub   (fl_sub),
    .fill_alloc (fill_alloc),
    .lk_hit_vec (lk_hit_vec),
    .fl_match   (fl_match),
    .free_vec   (free_vec)
  );

  subblock_tlb_victim #(
    .ENTRIES (ENTRIES)
  ) victim_i (
    .clk        (clk),
    .rst        (rst),
    .free_vec   (free_vec),
    .take       (take),
    .victim_idx (victim_idx)
  );

  subblock_tlb_store #(
    .DW (DW),
    .AW (AW)
  ) store_i (
    .clk (clk),
    .we  (op == OP_FILL),
    .wa  ({fill_idx, fl_sub}),
    .wd  ({fl_ppn, fl_attr}),
    .ra  ({lk_idx, lk_sub}),
    .rd  (rd_data)
  );

  // Lookup result register (RAM output register supplies the data)
  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= lk_valid && (|lk_hit_vec);
    off_q <= lk_vaddr[PAGE_BITS-1:0];
  end

  assign lk_hit   = hit_q;
  assign lk_paddr = hit_q ? {rd_data[DW-1:ATTR_W], off_q} : '0;
  assign lk_attr  = hit_q ? rd_data[ATTR_W-1:0] : '0;

  AST_HIT_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> $past(lk_valid)); // R2
  AST_FLUSH_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    (flush_all && !lk_valid) |=> !lk_hit); // R10

endmodule

// File: tb/subblock_tlb_tb.sv
`timescale 1ns/1ps
module subblock_tlb_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        lk_valid;
  logic [31:0] lk_vaddr;
  logic        lk_hit;
  logic [31:0] lk_paddr;
  logic [3:0]  lk_attr;
  logic        fl_valid;
  logic [19:0] fl_vpn;
  logic [19:0] fl_ppn;
  logic [3:0]  fl_attr;
  logic        inv_valid;
  logic [19:0] inv_vpn;
  logic        flush_all;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  subblock_tlb dut_i (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_attr(lk_attr),
    .fl_valid(fl_valid), .fl_vpn(fl_vpn), .fl_ppn(fl_ppn), .fl_attr(fl_attr),
    .inv_valid(inv_valid), .inv_vpn(inv_vpn), .flush_all(flush_all)
  );

  // Vector: {req[3:0], op[1:0], vaddr[31:0], ppn[19:0], attr[3:0], hit}
  // op: 0 fill, 1 lookup (check next cycle), 2 invalidate
  localparam int NV = 14;
  localparam logic [62:0] VEC [NV] = '{
    {4'd4,  2'd0, 32'h0001_0000, 20'h12345, 4'h3, 1'b0},  // R4 fill slot 0
    {4'd4,  2'd0, 32'h0001_5000, 20'h00777, 4'h5, 1'b0},  // R4 unrelated ppn, slot 5
    {4'd3,  2'd1, 32'h0001_0abc, 20'h12345, 4'h3, 1'b1},  // R3
    {4'd4,  2'd1, 32'h0001_5ffe, 20'h00777, 4'h5, 1'b1},  // R4
    {4'd2,  2'd1, 32'h0001_1000, 20'h00000, 4'h0, 1'b0},  // R2 invalid slot
    {4'd2,  2'd1, 32'h0002_0000, 20'h00000, 4'h0, 1'b0},  // R2 other region
    {4'd5,  2'd0, 32'h0001_5000, 20'h0aaaa, 4'h9, 1'b0},  // R5 overwrite
    {4'd5,  2'd1, 32'h0001_5004, 20'h0aaaa, 4'h9, 1'b1},  // R5
    {4'd4,  2'd1, 32'h0001_0004, 20'h12345, 4'h3, 1'b1},  // R4 neighbour kept
    {4'd8,  2'd2, 32'h0001_0000, 20'h00000, 4'h0, 1'b0},  // R8 drop slot 0
    {4'd8,  2'd1, 32'h0001_0000, 20'h00000, 4'h0, 1'b0},  // R8
    {4'd8,  2'd1, 32'h0001_5000, 20'h0aaaa, 4'h9, 1'b1},  // R8 sibling kept
    {4'd8,  2'd2, 32'h0003_0000, 20'h00000, 4'h0, 1'b0},  // R8 absent page
    {4'd8,  2'd1, 32'h0001_5000, 20'h0aaaa, 4'h9, 1'b1}   // R8
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    lk_valid = 0; fl_valid = 0; inv_valid = 0; flush_all = 0;
  endtask

  task automatic do_fill(input logic [31:0] va, input logic [19:0] ppn, input logic [3:0] at);
    @(negedge clk);
    fl_valid = 1; fl_vpn = va[31:12]; fl_ppn = ppn; fl_attr = at;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_inv(input logic [31:0] va);
    @(negedge clk);
    inv_valid = 1; inv_vpn = va[31:12];
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_all = 1;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic look(input string req, input logic [31:0] va, input bit eh,
                      input logic [19:0] ep, input logic [3:0] ea);
    logic [63:0] exp;
    @(negedge clk);
    lk_valid = 1; lk_vaddr = va;
    @(negedge clk);
    idle_inputs();
    exp = {27'd0, eh, (eh ? {ep, va[11:0]} : 32'd0), (eh ? ea : 4'd0)};
    chk(req, {27'd0, lk_hit, lk_paddr, lk_attr}, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    lk_vaddr = '0; fl_vpn = '0; fl_ppn = '0; fl_attr = '0; inv_vpn = '0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: reset state
    chk("R1 outputs", {27'd0, lk_hit, lk_paddr, lk_attr}, 64'd0);
    look("R1", 32'h0000_0000, 0, 0, 0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [62:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[62:59], i);
      case (v[58:57])
        2'd0: do_fill(v[56:25], v[24:5], v[4:1]);
        2'd2: do_inv(v[56:25]);
        default: look(tag, v[56:25], v[0], v[24:5], v[4:1]);
      endcase
    end

    // R2: no request -> hit low in the following cycle
    @(negedge clk);
    chk("R2 idle", {63'd0, lk_hit}, 64'd0);

    // R10: flush clears everything
    do_flush();
    look("R10", 32'h0001_5000, 0, 0, 0);

    // R6: eight regions, each into a free entry (entries 0..7)
    for (int k = 0; k < 8; k++) do_fill(32'((k + 1) << 16) | 32'(k << 12), 20'(32'h100 + k), 4'(k));
    for (int k = 0; k < 8; k++) look("R6", 32'((k + 1) << 16) | 32'(k << 12), 1, 20'(32'h100 + k), 4'(k));

    // R7: full, first eviction hits entry 0 (region 1), then entry 1 (region 2)
    do_fill(32'h0020_0000, 20'h0beef, 4'h1);
    look("R7 victim0", 32'h0001_0000, 0, 0, 0);
    look("R7 new", 32'h0020_0000, 1, 20'h0beef, 4'h1);
    look("R7 kept", 32'h0002_1000, 1, 20'h00101, 4'h1);
    do_fill(32'h0021_0000, 20'h0cafe, 4'h2);
    look("R7 victim1", 32'h0002_1000, 0, 0, 0);
    look("R7 kept3", 32'h0003_2000, 1, 20'h00102, 4'h2);

    // R9: release entry 4 (region 5, one slot) and reuse it ahead of pointer
    do_inv(32'h0005_4000);
    look("R9 dropped", 32'h0005_4000, 0, 0, 0);
    do_fill(32'h0022_0000, 20'h0d00d, 4'h6);
    look("R9 kept", 32'h0003_2000, 1, 20'h00102, 4'h2);
    look("R9 new", 32'h0022_0000, 1, 20'h0d00d, 4'h6);

    // R11: same-cycle fill and lookup of one page returns old contents
    @(negedge clk);
    fl_valid = 1; fl_vpn = 20'h00032; fl_ppn = 20'h00055; fl_attr = 4'h7;
    lk_valid = 1; lk_vaddr = 32'h0003_2010;
    @(negedge clk);
    idle_inputs();
    chk("R11 old", {27'd0, lk_hit, lk_paddr, lk_attr}, {27'd0, 1'b1, 32'h0010_2010, 4'h2});
    look("R11 new", 32'h0003_2010, 1, 20'h00055, 4'h7);

    // R12: flush beats fill
    @(negedge clk);
    flush_all = 1; fl_valid = 1; fl_vpn = 20'h00400; fl_ppn = 20'h00001; fl_attr = 4'h1;
    @(negedge clk);
    idle_inputs();
    look("R12 flush", 32'h0003_2000, 0, 0, 0);
    look("R12 fill dropped", 32'h0040_0000, 0, 0, 0);

    // R12: invalidate beats fill
    do_fill(32'h0041_0000, 20'h00011, 4'h3);
    @(negedge clk);
    inv_valid = 1; inv_vpn = 20'h00410; fl_valid = 1; fl_vpn = 20'h00420; fl_ppn = 20'h00022; fl_attr = 4'h4;
    @(negedge clk);
    idle_inputs();
    look("R12 inv", 32'h0041_0000, 0, 0, 0);
    look("R12 fill lost", 32'h0042_0000, 0, 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule